// File: doc/BRIEF.md
# Two-Way Pseudo-Associative Cache Lookup Controller

This block runs lookups into an external second-level cache. The cache is built from single-ported SRAM and arranged as two ways that are probed one after the other. For each set, an on-chip bit records the way that was most recently used. A lookup starts by reading the predicted way. The first read fetches the critical 16-byte beat together with that way's tag. The second read fetches the next beat of the same way, and its tag comes from the other way because the tag-way address bit is toggled. Reads of the predicted way continue back to back while the tags are compared as they come in.

When the predicted way's tag matches, the critical beat goes out to the requester as soon as it can, and the rest of the line follows on consecutive cycles. When only the other way matches, the speculative data is thrown away. The prediction bit for the set is turned to the way that matched, and the whole line is read again from the other way, starting at the critical beat. When neither tag matches, a one-cycle miss pulse is given and no further reads are issued. Lines are either 64 bytes (four beats) or 128 bytes (eight beats), chosen for each request. The SRAM answers a fixed number of cycles after each read, and that number is a parameter.

Top module: `l2_pseudo_lookup`

## Requirements
- R1: After reset, `busy`, `sram_rd`, `rsp_valid` and `miss` are low, and every set predicts way 0.
- R2: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` stays high until the lookup finishes. Requests presented while `busy` is high have no effect on the reads issued or the data returned.
- R3: The first read after a request has `sram_beat` equal to the critical beat, and both `sram_dway` and `sram_tway` are set to the predicted way. The second read has `sram_beat` equal to the critical beat plus one, `sram_dway` still set to the predicted way, and `sram_tway` set to the other way.
- R4: Beats are returned in wrapping order: critical, critical+1, and so on, modulo the line length. The line is 4 beats when `req_long`=0 and 8 beats when `req_long`=1. For a 4-beat line only bits [1:0] of `req_crit` are used.
- R5: On a predicted-way hit, the critical beat has `rsp_valid` high RD_LAT+1 cycles after the accepting edge. The remaining beats follow on consecutive cycles, and exactly one read is issued for each beat.
- R6: On an other-way hit, the line is read again from the other way. The first returned beat appears 2*RD_LAT+3 cycles after the accepting edge. The total number of reads is min(RD_LAT+1, beats) + beats.
- R7: An other-way hit sets the set's prediction to the way that hit. A predicted-way hit or a miss leaves the prediction unchanged.
- R8: On a miss, `miss` pulses for one cycle, RD_LAT+2 cycles after the accepting edge. No beat is returned. Only min(RD_LAT+1, beats) reads are issued, and none is issued from the miss cycle onward.
- R9: `rsp_last` is high only on the final beat of the line. `busy` is low in that same cycle, and `rsp_way` gives the way the data came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_tag | input | TAG_W | Tag to match |
| req_set | input | SET_W | Set index |
| req_crit | input | 3 | Critical beat within the line |
| req_long | input | 1 | 1 selects an 8-beat line, 0 selects a 4-beat line |
| busy | output | 1 | Lookup in progress; new requests are ignored |
| sram_rd | output | 1 | SRAM read strobe |
| sram_set | output | SET_W | SRAM set address |
| sram_beat | output | 3 | SRAM beat address |
| sram_dway | output | 1 | Way bit for the data array |
| sram_tway | output | 1 | Way bit for the tag array (the toggled bit) |
| sram_rdata | input | DATA_W | Returned data beat, RD_LAT cycles after the read |
| sram_rtag | input | TAG_W | Returned tag, RD_LAT cycles after the read |
| rsp_valid | output | 1 | Data beat valid |
| rsp_data | output | DATA_W | Data beat |
| rsp_last | output | 1 | Final beat of the line |
| rsp_way | output | 1 | Way that supplied the data |
| miss | output | 1 | One-cycle pulse when neither way matches |

## Verification
A wrong prediction bit shows up at the very next request to the same set. The first read carries the wrong way, and the critical beat arrives at 2*RD_LAT+3 cycles instead of RD_LAT+1, or the other way round. A bad issue or delivery counter gives wrong beat contents, a misplaced `rsp_last`, or a read count that differs from the expected one within a single line. A stale generation or missing drain lets leftover predicted-way data reach the requester after a restart or a miss. The sweep covers every set, both line lengths, every critical beat, and a hit in each way as well as a miss, so all of these faults surface within a few hundred cycles.

// File: rtl/l2pl_pkg.sv
package l2pl_pkg;

    localparam int BEAT_W      = 3;
    localparam int LONG_BEATS  = 8;
    localparam int SHORT_BEATS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_STREAM,
        ST_WAIT2,
        ST_RESTART,
        ST_DRAIN
    } lk_state_e;

    // Tracking record for one outstanding SRAM read.
    typedef struct packed {
        logic valid;
        logic gen;     // 1 for reads issued after a restart
        logic first;   // read that carries the predicted way's tag
        logic second;  // read that carries the other way's tag
    } rd_tag_t;

    function automatic logic [BEAT_W-1:0] beats_last(input logic long_line);
        return long_line ? BEAT_W'(LONG_BEATS - 1) : BEAT_W'(SHORT_BEATS - 1);
    endfunction

    function automatic logic [BEAT_W-1:0] wrap_beat(input logic [BEAT_W-1:0] crit,
                                                     input logic [BEAT_W-1:0] ofs,
                                                     input logic long_line);
        return (crit + ofs) & beats_last(long_line);
    endfunction

endpackage

// File: rtl/l2pl_mru_table.sv
module l2pl_mru_table #(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic             wr_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] way_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            way_bits <= '0;
        end else if (wr_en) begin
            way_bits[wr_set] <= wr_way;
        end
    end

    assign rd_way = way_bits[rd_set];

endmodule

// File: rtl/l2pl_meta_pipe.sv
module l2pl_meta_pipe
    import l2pl_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  rd_tag_t in_meta,
    output rd_tag_t out_meta,
    output logic    inflight
);
    rd_tag_t stg [RD_LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= in_meta;
            for (int i = 1; i < RD_LAT; i++) stg[i] <= stg[i-1];
        end
    end

    always_comb begin
        inflight = 1'b0;
        for (int i = 0; i < RD_LAT; i++) inflight = inflight | stg[i].valid;
    end

    assign out_meta = stg[RD_LAT-1];

endmodule

// File: rtl/l2pl_beat_ctr.sv
module l2pl_beat_ctr
    import l2pl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    output logic [BEAT_W:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/l2_pseudo_lookup.sv
module l2_pseudo_lookup
    import l2pl_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int SET_W  = 4,
    parameter int DATA_W = 128,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [SET_W-1:0]  req_set,
    input  logic [2:0]        req_crit,
    input  logic              req_long,
    output logic              busy,
    output logic              sram_rd,
    output logic [SET_W-1:0]  sram_set,
    output logic [2:0]        sram_beat,
    output logic              sram_dway,
    output logic              sram_tway,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic [TAG_W-1:0]  sram_rtag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic              rsp_way,
    output logic              miss
);
    lk_state_e          state_q, state_d;
    logic [TAG_W-1:0]   tag_q;
    logic [SET_W-1:0]   set_q;
    logic [BEAT_W-1:0]  crit_q;
    logic               long_q;
    logic               pred_q;
    logic               mru_way;

    logic [BEAT_W:0]    iss_cnt, dlv_cnt, n_beats;
    logic               accept, issuing, deliver, dlv_last;
    logic               tag_hit, restart_go, miss_go;
    rd_tag_t            in_meta, ret;
    logic               inflight;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign n_beats = {1'b0, beats_last(long_q)} + 1'b1;

    // Read issue
    always_comb begin
        issuing = ((state_q == ST_PROBE) || (state_q == ST_STREAM) ||
                   (state_q == ST_RESTART)) && (iss_cnt != n_beats);
        in_meta.valid  = issuing;
        in_meta.gen    = (state_q == ST_RESTART);
        in_meta.first  = issuing && !in_meta.gen && (iss_cnt == '0);
        in_meta.second = issuing && !in_meta.gen && (iss_cnt == (BEAT_W+1)'(1));
    end

    assign sram_rd   = issuing;
    assign sram_set  = set_q;
    assign sram_beat = wrap_beat(crit_q, iss_cnt[BEAT_W-1:0], long_q);
    assign sram_dway = (state_q == ST_RESTART) ? ~pred_q : pred_q;
    assign sram_tway = ((state_q != ST_RESTART) && (iss_cnt == (BEAT_W+1)'(1))) ? ~pred_q : pred_q;

    // Return handling
    assign tag_hit    = (sram_rtag == tag_q);
    assign dlv_last   = (dlv_cnt == {1'b0, beats_last(long_q)});
    assign restart_go = (state_q == ST_WAIT2) && ret.valid && ret.second && tag_hit;
    assign miss_go    = (state_q == ST_WAIT2) && ret.valid && ret.second && !tag_hit;

    always_comb begin
        deliver = 1'b0;
        if (ret.valid) begin
            unique case (state_q)
                ST_PROBE:   deliver = ret.first && tag_hit;
                ST_STREAM:  deliver = !ret.gen;
                ST_RESTART: deliver = ret.gen;
                default:    deliver = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_PROBE;
            ST_PROBE:   if (ret.valid && ret.first) state_d = tag_hit ? ST_STREAM : ST_WAIT2;
            ST_STREAM:  if (deliver && dlv_last) state_d = ST_IDLE;
            ST_WAIT2:   if (restart_go) state_d = ST_RESTART;
                        else if (miss_go) state_d = ST_DRAIN;
            ST_RESTART: if (deliver && dlv_last) state_d = ST_IDLE;
            ST_DRAIN:   if (!inflight) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tag_q     <= '0;
            set_q     <= '0;
            crit_q    <= '0;
            long_q    <= 1'b0;
            pred_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
            rsp_way   <= 1'b0;
            miss      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tag_q  <= req_tag;
                set_q  <= req_set;
                crit_q <= req_long ? req_crit : {1'b0, req_crit[1:0]};
                long_q <= req_long;
                pred_q <= mru_way;
            end
            rsp_valid <= deliver;
            rsp_data  <= sram_rdata;
            rsp_last  <= deliver && dlv_last;
            rsp_way   <= (state_q == ST_RESTART) ? ~pred_q : pred_q;
            miss      <= miss_go;
        end
    end

    l2pl_mru_table #(.SET_W(SET_W)) u_mru (
        .clk    (clk),
        .rst    (rst),
        .rd_set (req_set),
        .rd_way (mru_way),
        .wr_en  (restart_go),
        .wr_set (set_q),
        .wr_way (~pred_q)
    );

    l2pl_meta_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_meta  (in_meta),
        .out_meta (ret),
        .inflight (inflight)
    );

    l2pl_beat_ctr u_iss_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (accept || restart_go),
        .step  (issuing),
        .count (iss_cnt)
    );

    l2pl_beat_ctr u_dlv_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (accept || restart_go),
        .step  (deliver),
        .count (dlv_cnt)
    );

endmodule

// File: rtl/l2pl_lookup_checker.sv
module l2pl_lookup_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic sram_rd,
    input logic sram_dway,
    input logic sram_tway,
    input logic rsp_valid,
    input logic rsp_last,
    input logic miss
);
    // R2: reads happen only inside a lookup
    assert_rd_in_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        sram_rd |-> busy);

    // R3: first read uses one way for tag and data
    assert_probe_same_way_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (sram_rd && (sram_dway == sram_tway)));

    // R3: second read fetches the other way's tag
    assert_alt_tag_way_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> ##1 (sram_rd && (sram_tway != sram_dway)));

    // R8: nothing read or returned once a miss is flagged
    assert_quiet_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
        miss |-> (!sram_rd && !rsp_valid));

    // R9: final beat ends the lookup
    assert_last_frees_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_last) |-> !busy);

    // R9: non-final beats arrive while the lookup is still open
    assert_mid_beat_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_last) |-> busy);
endmodule

bind l2_pseudo_lookup l2pl_lookup_checker u_lookup_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .sram_rd   (sram_rd),
    .sram_dway (sram_dway),
    .sram_tway (sram_tway),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .miss      (miss)
);

// File: tb/l2_pseudo_lookup_bench.sv
`timescale 1ns/1ps
module l2_pseudo_lookup_bench;
    localparam int TAG_W  = 8;
    localparam int SET_W  = 4;
    localparam int DATA_W = 128;
    localparam int RD_LAT = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [SET_W-1:0]  req_set = '0;
    logic [2:0]        req_crit = '0;
    logic              req_long = 1'b0;
    logic              busy, sram_rd, sram_dway, sram_tway;
    logic [SET_W-1:0]  sram_set;
    logic [2:0]        sram_beat;
    logic [DATA_W-1:0] sram_rdata;
    logic [TAG_W-1:0]  sram_rtag;
    logic              rsp_valid, rsp_last, rsp_way, miss;
    logic [DATA_W-1:0] rsp_data;

    always #2.5 clk = ~clk;

    l2_pseudo_lookup #(.TAG_W(TAG_W), .SET_W(SET_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT))
    u_l2_pseudo_lookup (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
        .req_set(req_set), .req_crit(req_crit), .req_long(req_long), .busy(busy),
        .sram_rd(sram_rd), .sram_set(sram_set), .sram_beat(sram_beat),
        .sram_dway(sram_dway), .sram_tway(sram_tway), .sram_rdata(sram_rdata),
        .sram_rtag(sram_rtag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .rsp_way(rsp_way), .miss(miss)
    );

    function automatic logic [TAG_W-1:0] tag_of(input int w, input int s);
        return TAG_W'(s * 2 + w + 1);
    endfunction

    function automatic logic [DATA_W-1:0] dat_of(input int w, input int s, input int b);
        logic [31:0] wd;
        wd = {8'hA5, 7'd0, 1'(w), 4'd0, 4'(s), 5'd0, 3'(b)};
        return {4{wd}};
    endfunction

    // SRAM model: fixed read latency
    typedef struct packed {
        logic             dw;
        logic             tw;
        logic [SET_W-1:0] s;
        logic [2:0]       b;
    } bm_t;
    bm_t mp [RD_LAT];

    always_ff @(posedge clk) begin
        mp[0] <= '{dw: sram_dway, tw: sram_tway, s: sram_set, b: sram_beat};
        for (int i = 1; i < RD_LAT; i++) mp[i] <= mp[i-1];
    end

    always_comb begin
        sram_rdata = dat_of(int'(mp[RD_LAT-1].dw), int'(mp[RD_LAT-1].s), int'(mp[RD_LAT-1].b));
        sram_rtag  = tag_of(int'(mp[RD_LAT-1].tw), int'(mp[RD_LAT-1].s));
    end

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;
    bit mru_exp [16];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // t: 0/1 = way holding the line, 2 = absent
    task automatic run_req(input int s, input int t, input int crit, input bit lng, input bit junk);
        int n, p, kind, hitw, k, reads, nb, first_k, miss_k, data_bad, last_bad, way_bad;
        bit rd0_way, rd0_beat, rd1_ok, end_busy;
        n = lng ? 8 : 4;
        p = int'(mru_exp[s]);
        kind = (t == 2) ? 2 : ((t == p) ? 0 : 1);
        hitw = t;
        crit = crit % n;
        reads = 0; nb = 0; first_k = -1; miss_k = -1;
        data_bad = 0; last_bad = 0; way_bad = 0;
        rd0_way = 0; rd0_beat = 0; rd1_ok = 0; end_busy = 1;

        @(negedge clk);
        req_valid = 1'b1;
        req_set   = SET_W'(s);
        req_tag   = (t == 2) ? 8'hF0 : tag_of(t, s);
        req_crit  = 3'(crit);
        req_long  = lng;
        @(posedge clk); #1;
        k = 0;
        if (junk) begin
            req_set  = SET_W'(s ^ 1);
            req_tag  = tag_of(0, s ^ 1);
            req_crit = 3'(crit + 1);
        end else begin
            req_valid = 1'b0;
        end
        forever begin
            if (sram_rd) begin
                reads++;
                if (k == 0) begin
                    rd0_way  = (int'(sram_dway) == p) && (int'(sram_tway) == p);
                    rd0_beat = (int'(sram_beat) == crit) && (int'(sram_set) == s);
                end
                if (k == 1)
                    rd1_ok = (int'(sram_beat) == (crit + 1) % n) &&
                             (int'(sram_dway) == p) && (int'(sram_tway) == 1 - p);
            end
            if (rsp_valid) begin
                if (nb == 0) first_k = k;
                if (rsp_data !== dat_of(hitw, s, (crit + nb) % n)) data_bad++;
                if (rsp_last !== (nb == n - 1)) last_bad++;
                if (int'(rsp_way) != hitw) way_bad++;
                if (rsp_last) end_busy = busy;
                nb++;
            end
            if (miss) miss_k = k;
            if (!busy) break;
            @(posedge clk); #1;
            k++;
            if (k > 200) break;
        end
        req_valid = 1'b0;

        chk(rd0_way, "R7 first read way equals tracked prediction", int'(sram_dway), p);
        chk(rd0_beat, "R3 first read beat and set", 0, 1);
        chk(rd1_ok, "R3 second read toggles tag way", 0, 1);
        if (kind == 0) begin
            chk(first_k == RD_LAT + 1, "R5 critical beat latency", first_k, RD_LAT + 1);
            chk(reads == n, "R5 read count on first-way hit", reads, n);
        end else if (kind == 1) begin
            chk(first_k == 2 * RD_LAT + 3, "R6 restart beat latency", first_k, 2 * RD_LAT + 3);
            chk(reads == ((RD_LAT + 1 < n) ? RD_LAT + 1 : n) + n, "R6 read count on second-way hit",
                reads, ((RD_LAT + 1 < n) ? RD_LAT + 1 : n) + n);
            mru_exp[s] = 1'(t);
        end else begin
            chk(miss_k == RD_LAT + 2, "R8 miss pulse timing", miss_k, RD_LAT + 2);
            chk(nb == 0, "R8 no beats on miss", nb, 0);
            chk(reads == ((RD_LAT + 1 < n) ? RD_LAT + 1 : n), "R8 read count on miss",
                reads, (RD_LAT + 1 < n) ? RD_LAT + 1 : n);
        end
        if (kind != 2) begin
            chk(nb == n && data_bad == 0, junk ? "R2 busy-time request ignored, data intact"
                                              : "R4 wrapped beat data", data_bad, 0);
            chk(last_bad == 0 && way_bad == 0 && end_busy == 0, "R9 last flag, way, busy release",
                last_bad + way_bad, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mru_exp[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !sram_rd && !rsp_valid && !miss, "R1 reset outputs idle",
            int'(busy) + int'(sram_rd) + int'(rsp_valid) + int'(miss), 0);
        for (int ln = 0; ln < 2; ln++) begin
            for (int c = 0; c < (ln ? 8 : 4); c++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int t = 0; t < 3; t++) begin
                        run_req(s, t, c, 1'(ln), (s % 4) == 1);
                    end
                end
            end
        end
        // R7: hit in the last-used way again is now a predicted-way hit
        run_req(3, int'(mru_exp[3]), 0, 1'b0, 1'b0);
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule